// File: doc/BRIEF.md
# Staged Escalation Watchdog

This block guards one processor core against lockup. Software programs a length and an escalation mode, then writes a poke at regular intervals. If the pokes stop, the watchdog counts down one period and raises an interrupt. If the core is still silent after a second period, it asserts a non-maskable interrupt. After a third period it requests a chip soft reset. Each poke restarts the period and returns the watchdog to its quiet stage.

The timebase is a free-running prescaler that divides the input clock by 2^PRESC_W. Its tick decrements a counter of LEN_W+LOW_W bits. The programmed length fills only the upper LEN_W bits of that counter, so the length sets the timeout in coarse steps. With the default parameters each length unit is 65536 clocks, and the longest period is close to 2^32 clocks. The current escalation stage can be read back at any time. Bit 1 of that value tells an NMI handler that the watchdog caused the NMI, rather than some other source.

Top module: `wdog_core`

## Requirements
- R1: After reset irq_o, nmi_o and soft_rst_o are low, stat_o is 0, and the watchdog is disabled (mode 0).
- R2: The counter loads the length into its upper LEN_W bits, with zeros below. It decrements once every 2^PRESC_W clocks. An expiry therefore happens exactly 2^PRESC_W * length * 2^LOW_W clocks after the edge that accepts a config write or a poke. The period then repeats.
- R3: On the first expiry irq_o rises and stat_o becomes 1. irq_o stays high until a poke or a config write.
- R4: On the second expiry without a poke, nmi_o rises and stays high, and stat_o becomes 2. Bit 1 of stat_o marks a pending watchdog NMI. irq_o stays high.
- R5: On the third expiry with mode 3, soft_rst_o is high for exactly one clock and stat_o becomes 3.
- R6: Once stat_o is 3 the stage holds. No further soft_rst_o pulse occurs, however many periods elapse.
- R7: The mode sets how many stages are enabled: 0 none, 1 interrupt only, 2 interrupt and NMI, 3 all three. An expiry past the last enabled stage leaves the stage unchanged and pulses nothing.
- R8: With mode 0 the watchdog is disabled. Whatever the length, no output rises and stat_o stays 0.
- R9: A write with wr_sel_i=1 is a poke, and its data is ignored. It clears the stage to 0, drops irq_o and nmi_o, and starts a full new period.
- R10: A poke accepted on the same edge as an expiry wins. The stage stays 0 and a full new period starts.
- R11: A write with wr_sel_i=0 is a config write: mode in wr_data_i[1:0], length in wr_data_i[LEN_W+1:2]. It restarts the prescaler and the counter from the new length and clears the stage to 0.
- R12: A length of 0 gives a period of one prescaler tick, which is 2^PRESC_W clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects a config write, 1 selects a poke |
| wr_data_i | input | LEN_W+2 | Config data: [1:0] mode, [LEN_W+1:2] length |
| irq_o | output | 1 | Interrupt level, stage 1 and above |
| nmi_o | output | 1 | Non-maskable interrupt level, stage 2 and above |
| soft_rst_o | output | 1 | One-cycle soft-reset request |
| stat_o | output | 2 | Current stage: 0 idle, 1 interrupt, 2 NMI, 3 reset issued |

## Verification
Two events can meet on the same clock edge: a poke and the expiry of the period. The bench lets a period run to one clock short of its expiry, then drives the poke so that the write edge is the expiry edge itself. The poke must win. This is judged at the ports: irq_o stays low and stat_o stays 0 right after that edge, and irq_o rises exactly one full period later, neither earlier nor later.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IRQ  = 2'd1,
    ST_NMI  = 2'd2,
    ST_RST  = 2'd3
  } wd_stage_e;

  typedef enum logic [1:0] {
    MD_OFF     = 2'd0,
    MD_IRQ     = 2'd1,
    MD_IRQ_NMI = 2'd2,
    MD_ALL     = 2'd3
  } wd_mode_e;
endpackage

// File: rtl/wdog_prescale.sv
`timescale 1ns/1ps
module wdog_prescale #(
  parameter int PRESC_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic en_i,
  output logic tick_o
);
  localparam logic [PRESC_W-1:0] DIV_MAX = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 div_q <= '0;
    else if (restart_i || !en_i) div_q <= '0;
    else                         div_q <= div_q + 1'b1;
  end

  assign tick_o = en_i && (div_q == DIV_MAX);

  // R2
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_decr.sv
`timescale 1ns/1ps
module wdog_decr #(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] load_len_i,
  input  logic [LEN_W-1:0] run_len_i,
  output logic             expire_o
);
  localparam int CNT_W = LEN_W + LOW_W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end   = (cnt_q <= CNT_ONE);
  assign expire_o = tick_i && !restart_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= {load_len_i, {LOW_W{1'b0}}};
    else if (tick_i) begin
      if (at_end) cnt_q <= {run_len_i, {LOW_W{1'b0}}};
      else        cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !restart_i && !at_end) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_stage.sv
`timescale 1ns/1ps
module wdog_stage import wdog_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      restart_i,
  input  logic      expire_i,
  input  wd_mode_e  mode_i,
  output wd_stage_e stage_o,
  output logic      irq_o,
  output logic      nmi_o,
  output logic      soft_rst_o
);
  wd_stage_e stage_q, stage_d;
  logic      rst_q;

  always_comb begin
    stage_d = stage_q;
    if (expire_i) begin
      unique case (stage_q)
        ST_IDLE: if (mode_i != MD_OFF)     stage_d = ST_IRQ;
        ST_IRQ:  if (mode_i >= MD_IRQ_NMI) stage_d = ST_NMI;
        ST_NMI:  if (mode_i == MD_ALL)     stage_d = ST_RST;
        default: stage_d = stage_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE;
      rst_q   <= 1'b0;
    end else if (restart_i) begin
      stage_q <= ST_IDLE;
      rst_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      rst_q   <= (stage_q == ST_NMI) && (stage_d == ST_RST);
    end
  end

  assign stage_o    = stage_q;
  assign irq_o      = (stage_q != ST_IDLE);
  assign nmi_o      = (stage_q == ST_NMI) || (stage_q == ST_RST);
  assign soft_rst_o = rst_q;

  // R9
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (stage_q == ST_IDLE) && !soft_rst_o);
  // R5
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
  // R5
  rst_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (stage_q == ST_RST));
  // R7
  nmi_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (mode_i >= MD_IRQ_NMI));
  // R6
  one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> ((stage_q == $past(stage_q)) ||
                    (2'(stage_q) == 2'($past(stage_q)) + 2'd1)));
endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core import wdog_pkg::*; #(
  parameter int LEN_W   = 16,
  parameter int LOW_W   = 8,
  parameter int PRESC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [LEN_W+1:0] wr_data_i,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             soft_rst_o,
  output logic [1:0]       stat_o
);
  localparam int DATA_W = LEN_W + 2;

  logic [LEN_W-1:0] len_q;
  wd_mode_e         mode_q;
  logic             cfg_wr, restart, run_en, tick, expire;
  logic [LEN_W-1:0] load_len;
  wd_stage_e        stage;

  assign cfg_wr  = wr_en_i && !wr_sel_i;
  assign restart = wr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      mode_q <= MD_OFF;
    end else if (cfg_wr) begin
      len_q  <= wr_data_i[DATA_W-1:2];
      mode_q <= wd_mode_e'(wr_data_i[1:0]);
    end
  end

  assign load_len = cfg_wr ? wr_data_i[DATA_W-1:2] : len_q;
  assign run_en   = (mode_q != MD_OFF);

  wdog_prescale #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .en_i      (run_en),
    .tick_o    (tick)
  );

  wdog_decr #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_decr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .tick_i     (tick),
    .load_len_i (load_len),
    .run_len_i  (len_q),
    .expire_o   (expire)
  );

  wdog_stage u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .expire_i   (expire),
    .mode_i     (mode_q),
    .stage_o    (stage),
    .irq_o      (irq_o),
    .nmi_o      (nmi_o),
    .soft_rst_o (soft_rst_o)
  );

  assign stat_o = stage;

  // R8
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_OFF) |-> (!irq_o && !nmi_o && !soft_rst_o && stat_o == 2'd0));
  // R10
  poke_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> !irq_o);
endmodule

// File: tb/wdog_core_tb.sv
`timescale 1ns/1ps
module wdog_core_tb;
  localparam int LEN_W = 4;
  localparam int LOW_W = 2;
  localparam int PRESC_W = 2;
  localparam int UNIT = (1 << PRESC_W) * (1 << LOW_W); // 16 clocks per length unit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [LEN_W+1:0] wr_data = '0;
  logic irq, nmi, srst;
  logic [1:0] stat;

  int total = 0, bad = 0, rst_seen = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wdog_core #(.LEN_W(LEN_W), .LOW_W(LOW_W), .PRESC_W(PRESC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .irq_o(irq), .nmi_o(nmi), .soft_rst_o(srst), .stat_o(stat)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (srst) rst_seen++;
    end
  endtask

  task automatic wr(logic sel, logic [LEN_W+1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    if (srst) rst_seen++;
  endtask

  task automatic cfg(int mode, int len);
    wr(1'b0, {LEN_W'(len), 2'(mode)});
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    chk("R1 nmi", nmi, 0);
    chk("R1 srst", srst, 0);
    chk("R1 stat", stat, 0);
    step(100);
    chk("R1 disabled stat", stat, 0);
  endtask

  task automatic t_ladder;
    cfg(3, 2);
    step(2*UNIT - 1); chk("R2 irq before period", irq, 0);
    step(1);          chk("R3 irq", irq, 1); chk("R3 stat", stat, 1);
    step(2*UNIT - 1); chk("R3 irq held", irq, 1); chk("R4 nmi early", nmi, 0);
    step(1);          chk("R4 nmi", nmi, 1); chk("R4 stat", stat, 2);
    chk("R4 stat bit1", int'(stat[1]), 1); chk("R4 irq kept", irq, 1);
    rst_seen = 0;
    step(2*UNIT - 1); chk("R5 no early reset", rst_seen, 0);
    step(1);          chk("R5 srst", srst, 1); chk("R5 stat", stat, 3);
    step(1);          chk("R5 srst one cycle", srst, 0);
    step(4*2*UNIT);   chk("R6 single pulse", rst_seen, 1); chk("R6 stat", stat, 3);
  endtask

  task automatic t_poke;
    wr(1'b1, 6'h2A);
    chk("R9 stat", stat, 0); chk("R9 irq", irq, 0); chk("R9 nmi", nmi, 0);
    step(2*UNIT - 1); chk("R9 irq before period", irq, 0);
    step(1);          chk("R9 irq full period", irq, 1);
  endtask

  task automatic t_collide;
    cfg(3, 2);
    step(2*UNIT - 1);
    wr(1'b1, '0);     // poke edge coincides with the expiry edge
    chk("R10 irq", irq, 0); chk("R10 stat", stat, 0);
    step(2*UNIT - 1); chk("R10 irq before period", irq, 0);
    step(1);          chk("R10 irq after period", irq, 1);
  endtask

  task automatic t_mode1;
    cfg(1, 1); rst_seen = 0;
    step(UNIT);     chk("R7 mode1 irq", irq, 1); chk("R7 mode1 stat", stat, 1);
    step(3*UNIT);   chk("R7 mode1 stat held", stat, 1); chk("R7 mode1 nmi", nmi, 0);
    chk("R7 mode1 no reset", rst_seen, 0);
  endtask

  task automatic t_mode2;
    cfg(2, 1); rst_seen = 0;
    step(2*UNIT);   chk("R7 mode2 nmi", nmi, 1); chk("R7 mode2 stat", stat, 2);
    step(3*UNIT);   chk("R7 mode2 stat held", stat, 2); chk("R7 mode2 no reset", rst_seen, 0);
  endtask

  task automatic t_mode0;
    cfg(0, 15); rst_seen = 0;
    chk("R8 stat cleared", stat, 0);
    step(20*UNIT);
    chk("R8 irq", irq, 0); chk("R8 nmi", nmi, 0); chk("R8 stat", stat, 0);
    chk("R8 no reset", rst_seen, 0);
  endtask

  task automatic t_len0;
    cfg(3, 0);
    step((1 << PRESC_W) - 1); chk("R12 irq early", irq, 0);
    step(1);                  chk("R12 irq", irq, 1);
    step(1 << PRESC_W);       chk("R12 stat", stat, 2);
  endtask

  task automatic t_rewrite;
    cfg(3, 1);
    step(10);
    cfg(3, 3);
    chk("R11 stat", stat, 0);
    step(3*UNIT - 1); chk("R11 irq early", irq, 0);
    step(1);          chk("R11 irq", irq, 1);
    step(3*UNIT);     chk("R11 nmi", nmi, 1);
    cfg(3, 3);        chk("R11 clear", stat, 0); chk("R11 nmi clear", nmi, 0);
  endtask

  task automatic t_scale;
    cfg(3, 5);
    step(5*UNIT - 1); chk("R2 len5 early", irq, 0);
    step(1);          chk("R2 len5 irq", irq, 1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ladder;
    t_poke;
    t_collide;
    t_mode1;
    t_mode2;
    t_mode0;
    t_len0;
    t_rewrite;
    t_scale;
    finish_run;
  end

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run;
  end
endmodule